// File: doc/BRIEF.md
# Per-Channel TDC Fine-Time Calibrator

This block sits in a time-to-digital converter readout path and turns raw 10-bit fine-time codes into a normalised value. Hits arrive one at a time as a channel index plus a raw code over a valid/ready handshake. For each channel the block records the smallest and largest non-zero codes seen over a programmable number of hits. When that number is reached, the recorded span becomes the channel's calibration window and recording starts again. Until a channel has finished its first period, it uses a default window that is written through the register port.

Each hit is mapped linearly onto the range 0 to 1000, so that 0 stands for 0 ns and 1000 stands for 5 ns. Codes outside the window get fixed marker values. The quotient comes from a sequential divider, so the input is stalled while a division is in flight. Results leave through a valid/ready output that honours backpressure. A register write port selects calibration or raw pass-through, sets the hit count of a statistics period, and loads each channel's default window.

Top module: `tdc_fine_calib`

## Requirements
- R1: When bit 0 of the control register (address 0) is 0, the output value is the raw fine-time code zero-extended to 11 bits, the channel index is passed through, and hits do not advance any channel's statistics.
- R2: When bit 0 of the control register is 1 and lo < hi for the channel's window, a code ft with lo <= ft <= hi gives floor((ft - lo) * 1000 / (hi - lo)). So ft = lo gives 0 and ft = hi gives 1000.
- R3: With calibration on, a code below the window's lower limit gives 1010, and a code above the upper limit gives 1015.
- R4: With calibration on and a window whose lower and upper limits are equal, a code equal to that limit gives 0.
- R5: Until a channel completes its first statistics period, it uses its default window. That window is written at address 8 + channel, with the lower limit in bits 9:0 and the upper limit in bits 19:10. After reset every default window is lo = 0, hi = 1023.
- R6: The hit that completes a period (hit count equal to the statistics limit) is still calibrated with the old window. From the next hit on, the channel uses the smallest and largest non-zero codes of that period as lo and hi, and a new period starts empty.
- R7: A fine-time code of 0 is counted as a hit but changes neither the recorded minimum nor the recorded maximum.
- R8: Hits on one channel do not advance another channel's hit count or change its window.
- R9: The statistics limit (address 1) resets to DEF_STATS. A written value below MIN_STATS is stored as MIN_STATS.
- R10: in_ready is low from the accept of a hit until its result is taken. While out_valid is high and out_ready is low, out_valid, out_value and out_chan hold.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Hit offered |
| in_ready | output | 1 | Hit can be accepted |
| in_chan | input | CH_W (4) | Channel index of the hit, below NUM_CH |
| in_ft | input | 10 | Raw fine-time code |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_chan | output | CH_W (4) | Channel index of the result |
| out_value | output | 11 | Calibrated value, marker code, or raw code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register address: 0 control, 1 statistics limit, 8+n default window of channel n |
| reg_wdata | input | DW (20) | Register write data |

## Verification
Hits are sent against written default windows at both limits, just inside them, just outside them, and at a mid point. This separates an off-by-one in the range compare from a rounding fault in the divider. The bench also uses a window of zero width, which exposes a missing equal-limits branch. Hit sequences that mix in zero codes and cross the end of a period show whether zeros are kept out of the minimum, whether the switch to the measured window happens one hit late or one hit early, and whether the limit clamp acts. Interleaving two channels, running hits with calibration off, and holding the output stalled show per-channel isolation, the pass-through path, and that the handshake holds its data.

// File: rtl/tdc_calib_pkg.sv
// Shared constants and types of the fine-time calibrator.
// Assumes 10-bit raw fine-time codes and a 0..1000 output scale.
package tdc_calib_pkg;

    localparam int FT_W        = 10;
    localparam int OUT_W       = 11;
    localparam int FULL_SCALE  = 1000;
    localparam int CODE_UNDER  = 1010;
    localparam int CODE_OVER   = 1015;
    localparam int SCALE_W     = $clog2(FULL_SCALE + 1);
    localparam int WIN_W       = 2 * FT_W;

    // register addresses
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_STATS    = 1;
    localparam int ADDR_WIN_BASE = 8;

    // calibration window: upper limit in the high half, lower limit in the low half
    typedef struct packed {
        logic [FT_W-1:0] hi;
        logic [FT_W-1:0] lo;
    } window_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_OUT  = 2'd2
    } calib_state_t;

endpackage

// File: rtl/tdc_calib_regs.sv
// Write-only configuration registers: calibration enable, statistics limit
// with a lower clamp, and one default window per channel.
// Assumes DW >= WIN_W and that MIN_STATS <= DEF_STATS both fit in DW bits.
module tdc_calib_regs
    import tdc_calib_pkg::*;
#(
    parameter int NUM_CH    = 11,
    parameter int ADDR_W    = 5,
    parameter int DW        = 20,
    parameter int MIN_STATS = 10000,
    parameter int DEF_STATS = 100000,
    parameter int DEF_LO    = 0,
    parameter int DEF_HI    = 1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic              cal_en,
    output logic [DW-1:0]     stat_limit,
    output window_t           def_win [NUM_CH]
);

    localparam logic [DW-1:0] MIN_Q = DW'(MIN_STATS);
    localparam logic [DW-1:0] DEF_Q = DW'(DEF_STATS);
    localparam window_t       WIN_RST = '{hi: FT_W'(DEF_HI), lo: FT_W'(DEF_LO)};

    // control and statistics-limit registers, limit clamped on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_en     <= 1'b1;
            stat_limit <= DEF_Q;
        end else if (reg_we) begin
            if (reg_addr == ADDR_W'(ADDR_CTRL))
                cal_en <= reg_wdata[0];
            if (reg_addr == ADDR_W'(ADDR_STATS))
                stat_limit <= (reg_wdata < MIN_Q) ? MIN_Q : reg_wdata;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_win
            // default window register of one channel
            always_ff @(posedge clk) begin
                if (!rst_n)
                    def_win[gi] <= WIN_RST;
                else if (reg_we && reg_addr == ADDR_W'(ADDR_WIN_BASE + gi))
                    def_win[gi] <= window_t'(reg_wdata[WIN_W-1:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/tdc_calib_tracker.sv
// Per-channel statistics: counts hits, records the smallest and largest
// non-zero code, and at the end of each period latches them as the
// channel's measured window. Exposes the window each channel should use.
// Assumes stat_limit >= 1 and upd_ch < NUM_CH when upd is high.
module tdc_calib_tracker
    import tdc_calib_pkg::*;
#(
    parameter int NUM_CH = 11,
    parameter int CH_W   = 4,
    parameter int CNT_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [CH_W-1:0]  upd_ch,
    input  logic [FT_W-1:0]  upd_ft,
    input  logic [CNT_W-1:0] stat_limit,
    input  window_t          def_win [NUM_CH],
    output window_t          act_win [NUM_CH]
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            logic [CNT_W-1:0] cnt;
            logic [FT_W-1:0]  mn, mx, nmn, nmx;
            window_t          meas;
            logic             have_meas;
            logic             hit, last;

            // next extremes including the current code, zero codes ignored
            always_comb begin
                hit  = upd && (upd_ch == CH_W'(gi));
                nmn  = (upd_ft != '0 && upd_ft < mn) ? upd_ft : mn;
                nmx  = (upd_ft != '0 && upd_ft > mx) ? upd_ft : mx;
                last = (cnt + CNT_W'(1)) >= stat_limit;
            end

            // period bookkeeping and window latch of one channel
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt       <= '0;
                    mn        <= '1;
                    mx        <= '0;
                    meas      <= '0;
                    have_meas <= 1'b0;
                end else if (hit) begin
                    if (last) begin
                        meas      <= '{hi: nmx, lo: nmn};
                        have_meas <= 1'b1;
                        cnt       <= '0;
                        mn        <= '1;
                        mx        <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                        mn  <= nmn;
                        mx  <= nmx;
                    end
                end
            end

            // window in force: measured once available, default before that
            always_comb act_win[gi] = have_meas ? meas : def_win[gi];
        end
    endgenerate

endmodule

// File: rtl/tdc_calib_div.sv
// Restoring unsigned divider, one quotient bit per cycle. A start pulse
// loads the operands; done pulses for one cycle NUM_W cycles later.
// Assumes den is non-zero and start is only given while busy is low.
module tdc_calib_div #(
    parameter int NUM_W = 20,
    parameter int DEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);

    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0]  rem;
    logic [DEN_W-1:0]  dvs;
    logic [STEP_W-1:0] step;
    logic [DEN_W:0]    trial;
    logic              fits;

    // shifted partial remainder and its compare against the divisor
    always_comb begin
        trial = {rem, quot[NUM_W-1]};
        fits  = trial >= {1'b0, dvs};
    end

    // iteration register: numerator shifts out as quotient shifts in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            dvs  <= '0;
            quot <= '0;
            step <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem  <= '0;
                dvs  <= den;
                quot <= num;
                step <= STEP_W'(NUM_W);
                busy <= 1'b1;
            end else if (busy) begin
                rem  <= fits ? DEN_W'(trial - {1'b0, dvs}) : trial[DEN_W-1:0];
                quot <= {quot[NUM_W-2:0], fits};
                step <= step - STEP_W'(1);
                if (step == STEP_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tdc_fine_calib.sv
// Top of the fine-time calibrator. Accepts one hit at a time, picks the
// channel's window, classifies the code, runs the divider for in-window
// codes and presents the result until the consumer takes it.
// Assumes in_chan < NUM_CH; larger indices borrow channel 0's window and
// are not tracked.
module tdc_fine_calib
    import tdc_calib_pkg::*;
#(
    parameter int NUM_CH    = 11,
    parameter int CH_W      = $clog2(NUM_CH),
    parameter int ADDR_W    = 5,
    parameter int DW        = 20,
    parameter int MIN_STATS = 10000,
    parameter int DEF_STATS = 100000,
    parameter int DEF_LO    = 0,
    parameter int DEF_HI    = 1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [FT_W-1:0]   in_ft,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CH_W-1:0]   out_chan,
    output logic [OUT_W-1:0]  out_value,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata
);

    localparam int NUM_W = FT_W + SCALE_W;

    logic             cal_en;
    logic [DW-1:0]    stat_limit;
    window_t          def_win [NUM_CH];
    window_t          act_win [NUM_CH];
    window_t          sel_win;
    calib_state_t     state;
    logic             in_fire, job_cal, div_start, div_busy, div_done;
    logic [NUM_W-1:0] div_num, div_quot;
    logic [FT_W-1:0]  div_den, ft_off;
    logic             below, above, flat;

    tdc_calib_regs #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DW(DW),
        .MIN_STATS(MIN_STATS), .DEF_STATS(DEF_STATS),
        .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cal_en(cal_en), .stat_limit(stat_limit), .def_win(def_win)
    );

    tdc_calib_tracker #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(DW)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .upd(in_fire && cal_en), .upd_ch(in_chan), .upd_ft(in_ft),
        .stat_limit(stat_limit), .def_win(def_win), .act_win(act_win)
    );

    tdc_calib_div #(
        .NUM_W(NUM_W), .DEN_W(FT_W)
    ) u_div (
        .clk(clk), .rst_n(rst_n),
        .start(div_start), .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quot(div_quot)
    );

    // handshake on the input side
    always_comb begin
        in_ready = (state == ST_IDLE);
        in_fire  = in_valid && in_ready;
    end

    // window selection and classification of the offered code
    always_comb begin
        sel_win   = ({1'b0, in_chan} < (CH_W + 1)'(NUM_CH)) ? act_win[in_chan] : act_win[0];
        below     = in_ft < sel_win.lo;
        above     = in_ft > sel_win.hi;
        flat      = sel_win.hi == sel_win.lo;
        ft_off    = in_ft - sel_win.lo;
        div_num   = NUM_W'(ft_off) * NUM_W'(FULL_SCALE);
        div_den   = sel_win.hi - sel_win.lo;
        div_start = in_fire && cal_en && !below && !above && !flat;
    end

    // job control: capture, wait for the quotient, hold the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_value <= '0;
            job_cal   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (in_fire) begin
                        out_chan <= in_chan;
                        job_cal  <= cal_en;
                        if (!cal_en) begin
                            out_value <= OUT_W'(in_ft);
                            out_valid <= 1'b1;
                            state     <= ST_OUT;
                        end else if (below || above || flat) begin
                            out_value <= below ? OUT_W'(CODE_UNDER)
                                       : above ? OUT_W'(CODE_OVER) : '0;
                            out_valid <= 1'b1;
                            state     <= ST_OUT;
                        end else begin
                            state <= ST_DIV;
                        end
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        out_value <= div_quot[OUT_W-1:0];
                        out_valid <= 1'b1;
                        state     <= ST_OUT;
                    end
                end
                ST_OUT: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tdc_fine_calib_chk.sv
// Protocol and range checks for the calibrator, bound onto the top module.
// Assumes the same MIN_STATS as the instance it is bound to.
module tdc_fine_calib_chk #(
    parameter int CH_W      = 4,
    parameter int DW        = 20,
    parameter int MIN_STATS = 10000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [CH_W-1:0] out_chan,
    input logic [10:0]     out_value,
    input logic            cal_en,
    input logic            job_cal,
    input logic [DW-1:0]   stat_limit
);

    // R10: no new hit accepted while a result waits
    assert_busy_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10: a stalled result keeps its data
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_chan)));

    // R3: calibrated results are on the scale or one of the two markers
    assert_code_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && job_cal) |-> (out_value <= 11'd1000 || out_value == 11'd1010 || out_value == 11'd1015));

    // R1: pass-through results appear on the next cycle
    assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !cal_en) |=> out_valid);

    // R9: a write never leaves the limit below the floor
    assert_stat_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_limit >= DW'(MIN_STATS));

endmodule

bind tdc_fine_calib tdc_fine_calib_chk #(
    .CH_W(CH_W), .DW(DW), .MIN_STATS(MIN_STATS)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_chan(out_chan), .out_value(out_value),
    .cal_en(cal_en), .job_cal(job_cal), .stat_limit(stat_limit)
);

// File: tb/sim_tdc_fine_calib.sv
`timescale 1ns/1ps
module sim_tdc_fine_calib;

    localparam int NUM_CH = 11;
    localparam int CH_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [CH_W-1:0]   in_chan = '0;
    logic [9:0]        in_ft = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [CH_W-1:0]   out_chan;
    logic [10:0]       out_value;
    logic              reg_we = 1'b0;
    logic [4:0]        reg_addr = '0;
    logic [19:0]       reg_wdata = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tdc_fine_calib #(
        .NUM_CH(NUM_CH), .MIN_STATS(4), .DEF_STATS(6)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_ft(in_ft),
        .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan), .out_value(out_value),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );

    function automatic int model(int ft, int lo, int hi);
        if (ft < lo) return 1010;
        if (ft > hi) return 1015;
        if (hi == lo) return 0;
        return (ft - lo) * 1000 / (hi - lo);
    endfunction

    task automatic check_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_write(int addr, int data);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = 5'(addr);
        reg_wdata = 20'(data);
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic send_hit(int ch, int ft);
        @(negedge clk);
        in_valid = 1'b1;
        in_chan = CH_W'(ch);
        in_ft = 10'(ft);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic hit(int ch, int ft, int exp, string tag);
        send_hit(ch, ft);
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        check_val(tag, int'(out_value), exp);
        check_val({tag, " channel"}, int'(out_chan), ch);
        @(posedge clk);
        #1;
    endtask

    // R11: idle state after reset
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check_val("R11 out_valid after reset", int'(out_valid), 0);
        check_val("R11 in_ready after reset", int'(in_ready), 1);
    endtask

    // R1: pass-through with calibration off, no statistics advance
    task automatic t_passthrough();
        do_reset();
        reg_write(1, 4);
        reg_write(0, 2);
        hit(3, 777, 777, "R1 raw code");
        hit(10, 0, 0, "R1 raw zero");
        hit(8, 1023, 1023, "R1 raw max");
        for (int k = 0; k < 6; k++) hit(8, 100 + k, 100 + k, "R1 raw run");
        reg_write(0, 1);
        hit(8, 512, model(512, 0, 1023), "R1 no tracking while off");
    endtask

    // R2 R3 R5: written default window and its edges
    task automatic t_default_window();
        do_reset();
        reg_write(1, 1000);
        reg_write(8 + 2, (600 << 10) | 100);
        hit(2, 100, 0, "R2 at lower limit");
        hit(2, 600, 1000, "R2 at upper limit");
        hit(2, 350, 500, "R2 mid point");
        hit(2, 101, 2, "R2 just above lower");
        hit(2, 99, 1010, "R3 below window");
        hit(2, 601, 1015, "R3 above window");
        hit(2, 0, 1010, "R3 zero below window");
        hit(3, 1023, 1000, "R5 reset default on other channel");
        hit(3, 0, 0, "R5 reset default lower");
    endtask

    // R4: window of zero width
    task automatic t_flat_window();
        do_reset();
        reg_write(8 + 5, (300 << 10) | 300);
        hit(5, 300, 0, "R4 equal limits");
        hit(5, 299, 1010, "R4 below flat window");
        hit(5, 301, 1015, "R4 above flat window");
    endtask

    // R6 R7 R9: period end, zero codes, reset limit and clamp
    task automatic t_statistics();
        do_reset();
        for (int k = 1; k <= 6; k++)
            hit(9, 100 * k, model(100 * k, 0, 1023), "R9 default limit period");
        hit(9, 350, 500, "R9 R6 window after six hits");
        hit(9, 50, 1010, "R6 new window lower edge");
        reg_write(1, 1);
        hit(1, 0, 0, "R7 zero in period");
        hit(1, 200, model(200, 0, 1023), "R6 old window in period");
        hit(1, 50, model(50, 0, 1023), "R6 old window in period");
        hit(1, 400, model(400, 0, 1023), "R9 clamped limit closing hit");
        hit(1, 225, 500, "R7 R9 measured window ignores zero");
        hit(1, 49, 1010, "R6 below measured");
        hit(1, 401, 1015, "R6 above measured");
    endtask

    // R8: channels keep separate counts and windows
    task automatic t_isolation();
        do_reset();
        reg_write(1, 4);
        hit(6, 100, model(100, 0, 1023), "R8 ch6 hit");
        hit(6, 300, model(300, 0, 1023), "R8 ch6 hit");
        hit(6, 500, model(500, 0, 1023), "R8 ch6 hit");
        hit(7, 900, model(900, 0, 1023), "R8 ch7 hit");
        hit(7, 10, model(10, 0, 1023), "R8 ch7 hit");
        hit(6, 200, 195, "R8 ch6 closing hit");
        hit(6, 300, 500, "R8 ch6 measured window");
        hit(7, 512, 500, "R8 ch7 still default");
    endtask

    // R10: result held under backpressure, input blocked
    task automatic t_backpressure();
        int first;
        do_reset();
        out_ready = 1'b0;
        send_hit(4, 512);
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        first = int'(out_value);
        check_val("R10 stalled value", first, 500);
        repeat (5) @(negedge clk);
        check_val("R10 valid held", int'(out_valid), 1);
        check_val("R10 value held", int'(out_value), first);
        check_val("R10 channel held", int'(out_chan), 4);
        check_val("R10 input blocked", int'(in_ready), 0);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_val("R10 released valid", int'(out_valid), 0);
        check_val("R10 released ready", int'(in_ready), 1);
    endtask

    initial begin
        t_reset();
        t_passthrough();
        t_default_window();
        t_flat_window();
        t_statistics();
        t_isolation();
        t_backpressure();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule